// File: doc/BRIEF.md
# CAN Receive Record Ring

This block is the receive store of a CAN controller. Each accepted frame arrives as one parallel word: an extended-format flag, a remote-request flag, a 4-bit data length code, a 29-bit identifier and eight data bytes. The block packs the frame into a variable-length byte record and writes it into a 64-byte circular buffer, one byte per clock. A record counts as stored only once its last byte is written.

The host sees the oldest stored record through a 13-byte read window at offsets 16 to 28. A release command removes the oldest record. The record's length is decoded from its own header byte, and the read start pointer moves forward by that length, wrapping at the buffer size. If a new record would not fit in the free space, the frame is dropped and an overrun is flagged. While the controller is held in its reset mode, incoming frames are not taken. Status bits and one-cycle event strobes go to a separate register block.

Top module: `can_rx_ring`

## Requirements
- R1: Record byte 0 (header) carries the extended flag in bit 7, the remote flag in bit 6 and the raw data length code in bits 3:0; bits 5:4 are zero.
- R2: An extended record follows the header with ID[28:21], ID[20:13], ID[12:5], then ID[4:0] in bits 7:3 (low bits zero). A standard record follows it with ID[10:3], then ID[2:0] in bits 7:5 (low bits zero). Data bytes come next, data byte 0 being fr_data[7:0].
- R3: Record length is 3 plus the data count for standard frames and 5 plus the data count for extended frames. The data count is the length code clamped to 8, and zero for remote frames.
- R4: A frame whose record would push the stored byte count above 64 is discarded. rx_status bit 1 sets and ev_ovr pulses for one cycle. clr_ovr clears bit 1, and a new overrun in the same cycle wins.
- R5: A release moves the start pointer by the oldest record's length modulo 64, lowers msg_cnt by one and byte_cnt by that length. rx_status bit 0 is 1 exactly when msg_cnt is nonzero.
- R6: A release while msg_cnt is zero changes no count, pointer or status.
- R7: rd_data at offset 16+i (0 ≤ i ≤ 12) is the buffer byte at (start + i) mod 64. Any other offset reads 0.
- R8: While hold_reset is 1, frame starts are ignored and a store in progress is abandoned. When hold_reset falls, byte count, message count and both pointers are zeroed.
- R9: rx_status bit 4 is 1 while a record is being written. byte_cnt and msg_cnt change only at the clock that writes the last byte, when ev_rx pulses. fr_start during a store is ignored.
- R10: After rst_n, counts, status and strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_reset | input | 1 | Controller reset mode |
| fr_start | input | 1 | Offer a frame for storage |
| fr_ext | input | 1 | Extended identifier format |
| fr_rtr | input | 1 | Remote request frame |
| fr_dlc | input | 4 | Data length code |
| fr_id | input | 29 | Identifier, right-aligned |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_cmd | input | 1 | Release oldest record |
| clr_ovr | input | 1 | Clear overrun status |
| rd_off | input | 5 | Host read offset |
| rd_data | output | 8 | Window byte at rd_off |
| rx_status | output | 8 | Bit 0 records present, bit 1 overrun, bit 4 storing |
| byte_cnt | output | 7 | Stored bytes |
| msg_cnt | output | 7 | Stored records |
| ev_rx | output | 1 | Record committed strobe |
| ev_ovr | output | 1 | Overrun strobe |

## Verification
Seeded random frames mix extended and standard identifiers, remote frames and length codes from 0 to 15, so the ring fills, overruns and wraps past address 63 many times. Each release then tests that the length decoded from the stored header matches what the bench model computed at write time. Directed patterns separate the cases a random mix hides: a remote frame with a nonzero length code (no data bytes), codes above 8 (clamping), a release on an empty ring, offsets just outside the window, a store sampled mid-write, and a frame offered in reset mode.

// File: rtl/can_rx_ring.sv
module can_rx_ring #(
  parameter int DEPTH = 64,
  parameter int WIN   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_reset,
  input  logic        fr_start,
  input  logic        fr_ext,
  input  logic        fr_rtr,
  input  logic [3:0]  fr_dlc,
  input  logic [28:0] fr_id,
  input  logic [63:0] fr_data,
  input  logic        rel_cmd,
  input  logic        clr_ovr,
  input  logic [4:0]  rd_off,
  output logic [7:0]  rd_data,
  output logic [7:0]  rx_status,
  output logic [$clog2(DEPTH):0] byte_cnt,
  output logic [$clog2(DEPTH):0] msg_cnt,
  output logic        ev_rx,
  output logic        ev_ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [4:0] WBASE = 5'd16;
  localparam logic [4:0] WLAST = 5'(16 + WIN - 1);

  function automatic logic [3:0] rec_len(input logic ext, input logic rtr, input logic [3:0] dlc);
    logic [3:0] d;
    d = rtr ? 4'd0 : ((dlc > 4'd8) ? 4'd8 : dlc);
    return (ext ? 4'd5 : 4'd3) + d;
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] start_ptr, wptr;
  logic          busy, ovr, hold_q;
  logic [3:0]    k, f_len;
  logic          f_ext, f_rtr;
  logic [3:0]    f_dlc;
  logic [28:0]   f_id;
  logic [63:0]   f_data;
  logic [7:0]    cur_byte;
  logic [3:0]    dsel;

  wire [3:0] in_len  = rec_len(fr_ext, fr_rtr, fr_dlc);
  wire [3:0] rel_len = rec_len(mem[start_ptr][7], mem[start_ptr][6], mem[start_ptr][3:0]);
  wire leave   = hold_q && !hold_reset;
  wire do_rel  = rel_cmd && (msg_cnt != '0);
  wire commit  = busy && !hold_reset && (k == f_len - 4'd1);
  wire no_room = ({1'b0, byte_cnt} + (CW+1)'(in_len)) > (CW+1)'(DEPTH);
  wire take    = fr_start && !busy && !hold_reset && !leave;

  assign dsel = k - (f_ext ? 4'd5 : 4'd3);

  always_comb begin
    cur_byte = f_data[{dsel[2:0], 3'b000} +: 8];
    if (k == 4'd0) cur_byte = {f_ext, f_rtr, 2'b00, f_dlc};
    else if (f_ext) begin
      case (k)
        4'd1: cur_byte = f_id[28:21];
        4'd2: cur_byte = f_id[20:13];
        4'd3: cur_byte = f_id[12:5];
        4'd4: cur_byte = {f_id[4:0], 3'b000};
        default: ;
      endcase
    end else begin
      case (k)
        4'd1: cur_byte = f_id[10:3];
        4'd2: cur_byte = {f_id[2:0], 5'b00000};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (busy && !hold_reset) mem[wptr + AW'(k)] <= cur_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ptr <= '0; wptr <= '0; byte_cnt <= '0; msg_cnt <= '0;
      busy <= 1'b0; ovr <= 1'b0; hold_q <= 1'b0; k <= '0;
      ev_rx <= 1'b0; ev_ovr <= 1'b0;
      f_ext <= 1'b0; f_rtr <= 1'b0; f_dlc <= '0; f_id <= '0; f_data <= '0; f_len <= '0;
    end else begin
      hold_q <= hold_reset;
      ev_rx  <= 1'b0;
      ev_ovr <= 1'b0;
      if (clr_ovr) ovr <= 1'b0;
      if (leave) begin
        start_ptr <= '0; wptr <= '0; byte_cnt <= '0; msg_cnt <= '0; busy <= 1'b0;
      end else begin
        byte_cnt <= byte_cnt + (commit ? CW'(f_len) : '0) - (do_rel ? CW'(rel_len) : '0);
        msg_cnt  <= msg_cnt + CW'(commit) - CW'(do_rel);
        if (do_rel) start_ptr <= start_ptr + AW'(rel_len);
        if (hold_reset) busy <= 1'b0;
        else if (busy) begin
          k <= k + 4'd1;
          if (commit) begin
            busy  <= 1'b0;
            wptr  <= wptr + AW'(f_len);
            ev_rx <= 1'b1;
          end
        end else if (take) begin
          if (no_room) begin
            ovr    <= 1'b1;
            ev_ovr <= 1'b1;
          end else begin
            busy <= 1'b1; k <= '0; f_len <= in_len;
            f_ext <= fr_ext; f_rtr <= fr_rtr; f_dlc <= fr_dlc; f_id <= fr_id; f_data <= fr_data;
          end
        end
      end
    end
  end

  wire in_win = (rd_off >= WBASE) && (rd_off <= WLAST);
  assign rd_data   = in_win ? mem[start_ptr + AW'(rd_off - WBASE)] : 8'h00;
  assign rx_status = {3'b000, busy, 2'b00, ovr, msg_cnt != '0};

  // R4
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_ovr |-> rx_status[1]);
  // R8
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) hold_reset |=> !busy);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_cnt <= CW'(DEPTH));
  // R5
  empty_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n) (msg_cnt == '0) |-> (byte_cnt == '0));
  // R6
  empty_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cmd && msg_cnt == '0 && !leave) |=> $stable(start_ptr));
  // R9
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rx && !$past(rel_cmd) && !$past(leave)) |-> $stable(msg_cnt));
endmodule

// File: tb/test_can_rx_ring.sv
module test_can_rx_ring;
  logic clk = 0, rst_n = 0, hold_reset = 0, fr_start = 0, fr_ext = 0, fr_rtr = 0;
  logic [3:0] fr_dlc = 0;
  logic [28:0] fr_id = 0;
  logic [63:0] fr_data = 0;
  logic rel_cmd = 0, clr_ovr = 0;
  logic [4:0] rd_off = 0;
  logic [7:0] rd_data, rx_status;
  logic [6:0] byte_cnt, msg_cnt;
  logic ev_rx, ev_ovr;

  can_rx_ring i_can_rx_ring (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mq [64];
  int mstart = 0, mbytes = 0, mmsgs = 0, movr = 0;
  logic [31:0] seed;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_up();
    end
  end

  function automatic int mlen(input bit ext, input bit rtr, input int dlc);
    return (ext ? 5 : 3) + (rtr ? 0 : (dlc > 8 ? 8 : dlc));
  endfunction

  function automatic logic [7:0] mbyte(input bit ext, input bit rtr, input logic [3:0] dlc,
                                       input logic [28:0] id, input logic [63:0] d, input int k);
    int h = ext ? 5 : 3;
    if (k == 0) return {ext, rtr, 2'b00, dlc};
    if (ext) begin
      if (k == 1) return id[28:21];
      if (k == 2) return id[20:13];
      if (k == 3) return id[12:5];
      if (k == 4) return {id[4:0], 3'b000};
    end else begin
      if (k == 1) return id[10:3];
      if (k == 2) return {id[2:0], 5'b00000};
    end
    return d[(k - h) * 8 +: 8];
  endfunction

  task automatic send(input bit ext, input bit rtr, input logic [3:0] dlc,
                      input logic [28:0] id, input logic [63:0] d);
    int len = mlen(ext, rtr, dlc);
    @(negedge clk);
    fr_start = 1; fr_ext = ext; fr_rtr = rtr; fr_dlc = dlc; fr_id = id; fr_data = d;
    @(negedge clk);
    fr_start = 0;
    while (rx_status[4]) @(negedge clk);
    if (mbytes + len > 64) movr = 1;
    else begin
      for (int k = 0; k < len; k++) mq[(mstart + mbytes + k) % 64] = mbyte(ext, rtr, dlc, id, d, k);
      mbytes += len; mmsgs++;
    end
  endtask

  task automatic release_one;
    @(negedge clk); rel_cmd = 1;
    @(negedge clk); rel_cmd = 0;
    if (mmsgs > 0) begin
      int len = mlen(mq[mstart][7], mq[mstart][6], mq[mstart][3:0]);
      mstart = (mstart + len) % 64; mbytes -= len; mmsgs--;
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " byte_cnt"}, byte_cnt, mbytes);
    chk({req, " msg_cnt"}, msg_cnt, mmsgs);
    chk({req, " status"}, {rx_status[4], rx_status[1], rx_status[0]}, {1'b0, movr[0], mmsgs != 0});
    for (int i = 0; i < 13 && i < mbytes; i++) begin
      rd_off = 5'(16 + i); #1;
      chk({req, " window"}, rd_data, mq[(mstart + i) % 64]);
    end
  endtask

  initial begin
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", rx_status, 0);
    chk("R10 counts", {byte_cnt, msg_cnt, ev_rx, ev_ovr}, 0);
    rst_n = 1;
    @(negedge clk);
    // R6 release on empty ring
    release_one();
    compare_all("R6");
    // R1 R2 R3 standard remote frame, nonzero dlc
    send(0, 1, 4'd5, 29'h5A3, 64'h0);
    rd_off = 16; #1; chk("R1 header", rd_data, 8'h45);
    rd_off = 17; #1; chk("R2 std id hi", rd_data, 8'hB4);
    rd_off = 18; #1; chk("R2 std id lo", rd_data, 8'h60);
    chk("R3 rtr length", byte_cnt, 3);
    // R9 mid-store sample on an extended dlc=12 frame
    @(negedge clk);
    fr_start = 1; fr_ext = 1; fr_rtr = 0; fr_dlc = 4'd12; fr_id = 29'h1ABCDEF1;
    fr_data = 64'h8877665544332211;
    @(negedge clk); fr_start = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 storing bit", rx_status[4], 1);
    chk("R9 count held", msg_cnt, 1);
    fr_start = 1; fr_ext = 0; fr_dlc = 0;
    @(negedge clk); fr_start = 0;
    while (rx_status[4]) @(negedge clk);
    for (int k = 0; k < 13; k++) mq[(mstart + mbytes + k) % 64] = mbyte(1, 0, 4'd12, 29'h1ABCDEF1, 64'h8877665544332211, k);
    mbytes += 13; mmsgs++;
    compare_all("R9 R3 clamp");
    release_one();
    rd_off = 16; #1; chk("R1 ext header", rd_data, 8'h8C);
    rd_off = 20; #1; chk("R2 ext id low", rd_data, 8'h88);
    compare_all("R5");
    // R7 outside window
    rd_off = 15; #1; chk("R7 offset 15", rd_data, 0);
    rd_off = 29; #1; chk("R7 offset 29", rd_data, 0);
    // R8 reset mode
    hold_reset = 1;
    @(negedge clk);
    fr_start = 1; fr_ext = 0; fr_rtr = 0; fr_dlc = 2;
    @(negedge clk); fr_start = 0;
    @(negedge clk);
    chk("R8 ignored in reset", {rx_status[4], byte_cnt}, {1'b0, 7'(mbytes)});
    hold_reset = 0;
    @(negedge clk);
    mstart = 0; mbytes = 0; mmsgs = 0;
    compare_all("R8 leave");
    // random mix R4 R5 R7
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) send($urandom_range(0, 1), $urandom_range(0, 3) == 0, 4'($urandom_range(0, 15)),
                       29'($urandom), {$urandom, $urandom});
      else if (op < 9) release_one();
      else begin
        @(negedge clk); clr_ovr = 1; @(negedge clk); clr_ovr = 0; movr = 0;
      end
      compare_all("R4 R5 R7 random");
    end
    while (mmsgs > 0) release_one();
    compare_all("R5 drained");
    finish_up();
  end
endmodule